// File: doc/BRIEF.md
# External Bus Access Timing Sequencer

This block turns single read or write requests from an internal port into timed accesses on an asynchronous external memory bus. The upper address bits pick one of several zones. Each zone has its own timing word, with separate phase settings for reads and for writes.

Every access passes through three phases. In the lead phase only the chip select is driven. In the active phase the read or write strobe is also driven. In the trail phase the chip select is held while the strobe is released. A per-zone doubling bit stretches the programmed phase lengths. A per-zone ready-enable bit lets an external ready line add wait cycles to the active phase.

The block accepts a request only while it is idle. For a read, it captures the bus data in the last active cycle. It pulses done once the access has finished. Illegal settings are not checked: whatever values are programmed are run.

Top module: `ext_bus_seq`

## Requirements
- R1: Address bits [15:14] select the zone: values 0, 1 and 2 pick that zone, and value 3 maps to zone 2. Only that zone's active-low chip select bit, cs_n_o[zone], is low, and it stays low for every lead, active and trail cycle of the access.
- R2: Zone z's timing word is cfg_i[16*z +: 16], with these fields:
  - [1:0] read lead
  - [4:2] read active
  - [6:5] read trail
  - [8:7] write lead
  - [11:9] write active
  - [13:12] write trail
  - [14] doubling
  - [15] ready enable

  Reads use the read fields and writes use the write fields. The word is sampled when the request is accepted.
- R3: With doubling clear, lead lasts LEAD cycles, active lasts ACTIVE+1+WS cycles and trail lasts TRAIL cycles.
- R4: With doubling set, lead lasts 2*LEAD cycles, active lasts 2*ACTIVE+1+WS cycles and trail lasts 2*TRAIL cycles. The +1 and WS terms are not doubled.
- R5: With ready enable set, rdy_i is sampled in the final programmed active cycle and in every added cycle after it. Each low sample adds one wait cycle (WS). With ready enable clear, rdy_i is ignored and WS is 0.
- R6: rd_n_o is low only in the active cycles of a read, and wr_n_o is low only in the active cycles of a write. During a whole write access, bus_data_oe_o is high and bus_data_o carries the write data. bus_addr_o carries the request address for the whole access.
- R7: For a read, bus_data_i is captured in the last active cycle. It is presented on rdata_o when done_o rises and held until the next read completes.
- R8: busy_o is high from the cycle after acceptance through the last trail cycle. done_o is high for exactly one cycle, the cycle after the access ends.
- R9: req_i is accepted only while busy_o is low. A request raised while busy is dropped and does not change the running access.
- R10: A lead or trail setting of 0 is not rejected. The access runs with no lead cycles or no trail cycles; active still lasts at least one cycle.
- R11: While rst_ni is low, every chip select, rd_n_o and wr_n_o are high, and busy_o, done_o and bus_data_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write data |
| cfg_i | input | NUM_ZONES*16 | Per-zone timing words |
| rdy_i | input | 1 | External ready |
| bus_data_i | input | DATA_W | Read data from the bus |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| cs_n_o | output | NUM_ZONES | Zone chip selects, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_data_o | output | DATA_W | Bus write data |
| bus_data_oe_o | output | 1 | Write data drive enable |

## Verification
The bench builds the block with its default parameters: 16-bit address and data, three zones, and 2/3/2-bit lead/active/trail fields. With these widths, the largest doubled setting (a 6-cycle lead, 15-cycle active and 6-cycle trail) runs in a few dozen cycles, so the full range of every field is cheap to reach. Three zones plus the spare fourth decode value exercise the clamping of the zone index. The bench's ready model holds ready low for a chosen number of active cycles, which covers the cases of no wait, several waits, and ready being ignored.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LEAD, PH_ACT, PH_TRAIL} phase_e;
endpackage

// File: rtl/ebs_zone_sel.sv
module ebs_zone_sel #(
  parameter int NUM_ZONES = 3,
  parameter int ZSEL_W    = 2,
  parameter int LEAD_W    = 2,
  parameter int ACT_W     = 3,
  parameter int TRAIL_W   = 2,
  parameter int CFG_W     = 16
) (
  input  logic [ZSEL_W-1:0]          addr_hi_i,
  input  logic                       we_i,
  input  logic [NUM_ZONES*CFG_W-1:0] cfg_i,
  output logic [NUM_ZONES-1:0]       zone_oh_o,
  output logic [LEAD_W:0]            lead_len_o,
  output logic [ACT_W:0]             act_len_o,
  output logic [TRAIL_W:0]           trail_len_o,
  output logic                       use_rdy_o
);
  localparam int F_W     = LEAD_W + ACT_W + TRAIL_W;
  localparam int RL_LO   = 0;
  localparam int RA_LO   = LEAD_W;
  localparam int RT_LO   = LEAD_W + ACT_W;
  localparam int WL_LO   = F_W;
  localparam int WA_LO   = F_W + LEAD_W;
  localparam int WT_LO   = F_W + LEAD_W + ACT_W;
  localparam int DBL_BIT = 2 * F_W;
  localparam int RDY_BIT = 2 * F_W + 1;
  localparam logic [ZSEL_W-1:0] LAST_Z = ZSEL_W'(NUM_ZONES - 1);

  logic [CFG_W-1:0]   zcfg [NUM_ZONES];
  logic [ZSEL_W-1:0]  idx;
  logic [CFG_W-1:0]   sel;
  logic [LEAD_W-1:0]  lead;
  logic [ACT_W-1:0]   act;
  logic [TRAIL_W-1:0] trail;
  logic               dbl;

  // spare decode values fold onto the last zone
  assign idx = (addr_hi_i > LAST_Z) ? LAST_Z : addr_hi_i;

  for (genvar g = 0; g < NUM_ZONES; g++) begin : g_zone
    assign zcfg[g]      = cfg_i[g*CFG_W +: CFG_W];
    assign zone_oh_o[g] = (idx == ZSEL_W'(g));
  end

  assign sel   = zcfg[idx];
  assign lead  = we_i ? sel[WL_LO +: LEAD_W]  : sel[RL_LO +: LEAD_W];
  assign act   = we_i ? sel[WA_LO +: ACT_W]   : sel[RA_LO +: ACT_W];
  assign trail = we_i ? sel[WT_LO +: TRAIL_W] : sel[RT_LO +: TRAIL_W];
  assign dbl   = sel[DBL_BIT];
  assign use_rdy_o = sel[RDY_BIT];

  assign lead_len_o  = dbl ? {lead, 1'b0}  : {1'b0, lead};
  assign act_len_o   = dbl ? {act, 1'b0}   : {1'b0, act};
  assign trail_len_o = dbl ? {trail, 1'b0} : {1'b0, trail};
endmodule

// File: rtl/ebs_phase_ctrl.sv
module ebs_phase_ctrl
  import ebs_pkg::*;
#(
  parameter int LEN_L_W = 3,
  parameter int LEN_A_W = 4,
  parameter int LEN_T_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LEN_L_W-1:0] lead_len_i,
  input  logic [LEN_A_W-1:0] act_len_i,
  input  logic [LEN_T_W-1:0] trail_len_i,
  input  logic               use_rdy_i,
  input  logic               rdy_i,
  output phase_e             phase_o,
  output logic               act_last_o,
  output logic               done_o
);
  localparam int CNT_W0 = (LEN_L_W > LEN_A_W) ? LEN_L_W : LEN_A_W;
  localparam int CNT_W  = (CNT_W0 > LEN_T_W) ? CNT_W0 : LEN_T_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [LEN_A_W-1:0] act_q;
  logic [LEN_T_W-1:0] trail_q;
  logic               use_rdy_q;
  logic               done_q;
  logic               cnt_zero;
  logic               finish;

  assign cnt_zero   = (cnt_q == '0);
  assign act_last_o = (phase_q == PH_ACT) && cnt_zero && (!use_rdy_q || rdy_i);
  assign finish     = (act_last_o && (trail_q == '0)) ||
                      ((phase_q == PH_TRAIL) && cnt_zero);
  assign phase_o    = phase_q;
  assign done_o     = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      act_q     <= '0;
      trail_q   <= '0;
      use_rdy_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= finish;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          act_q     <= act_len_i;
          trail_q   <= trail_len_i;
          use_rdy_q <= use_rdy_i;
          if (lead_len_i != '0) begin
            phase_q <= PH_LEAD;
            cnt_q   <= CNT_W'(lead_len_i) - ONE;
          end else begin
            phase_q <= PH_ACT;
            cnt_q   <= CNT_W'(act_len_i);
          end
        end
        PH_LEAD: begin
          if (cnt_zero) begin
            phase_q <= PH_ACT;
            cnt_q   <= CNT_W'(act_q);
          end else cnt_q <= cnt_q - ONE;
        end
        PH_ACT: begin
          if (!cnt_zero) cnt_q <= cnt_q - ONE;
          else if (act_last_o) begin
            if (trail_q != '0) begin
              phase_q <= PH_TRAIL;
              cnt_q   <= CNT_W'(trail_q) - ONE;
            end else phase_q <= PH_IDLE;
          end
        end
        PH_TRAIL: begin
          if (cnt_zero) phase_q <= PH_IDLE;
          else cnt_q <= cnt_q - ONE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R5: low ready at the last programmed cycle keeps the active phase
  a_r5_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACT && cnt_zero && use_rdy_q && !rdy_i) |=> (phase_q == PH_ACT && cnt_zero));
  a_r5_rdy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ACT && cnt_zero && !use_rdy_q) |=> (phase_q != PH_ACT));
  a_r3_lead_to_act: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LEAD && cnt_zero) |=> (phase_q == PH_ACT));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ebs_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int NUM_ZONES = 3,
  parameter int LEAD_W    = 2,
  parameter int ACT_W     = 3,
  parameter int TRAIL_W   = 2,
  localparam int CFG_W    = 2 * (LEAD_W + ACT_W + TRAIL_W) + 2,
  localparam int ZSEL_W   = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NUM_ZONES*CFG_W-1:0] cfg_i,
  input  logic                       rdy_i,
  input  logic [DATA_W-1:0]          bus_data_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_ZONES-1:0]       cs_n_o,
  output logic                       rd_n_o,
  output logic                       wr_n_o,
  output logic [ADDR_W-1:0]          bus_addr_o,
  output logic [DATA_W-1:0]          bus_data_o,
  output logic                       bus_data_oe_o
);
  logic [NUM_ZONES-1:0] zone_oh, zone_q;
  logic [LEAD_W:0]      lead_len;
  logic [ACT_W:0]       act_len;
  logic [TRAIL_W:0]     trail_len;
  logic                 use_rdy;
  logic                 start;
  logic                 act_last;
  phase_e               phase;
  logic                 we_q;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q, rdata_q;

  ebs_zone_sel #(
    .NUM_ZONES(NUM_ZONES), .ZSEL_W(ZSEL_W), .LEAD_W(LEAD_W),
    .ACT_W(ACT_W), .TRAIL_W(TRAIL_W), .CFG_W(CFG_W)
  ) u_zone (
    .addr_hi_i  (addr_i[ADDR_W-1 -: ZSEL_W]),
    .we_i       (we_i),
    .cfg_i      (cfg_i),
    .zone_oh_o  (zone_oh),
    .lead_len_o (lead_len),
    .act_len_o  (act_len),
    .trail_len_o(trail_len),
    .use_rdy_o  (use_rdy)
  );

  ebs_phase_ctrl #(
    .LEN_L_W(LEAD_W + 1), .LEN_A_W(ACT_W + 1), .LEN_T_W(TRAIL_W + 1)
  ) u_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .lead_len_i (lead_len),
    .act_len_i  (act_len),
    .trail_len_i(trail_len),
    .use_rdy_i  (use_rdy),
    .rdy_i      (rdy_i),
    .phase_o    (phase),
    .act_last_o (act_last),
    .done_o     (done_o)
  );

  assign start = req_i && (phase == PH_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zone_q  <= '0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (start) begin
        zone_q  <= zone_oh;
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (act_last && !we_q) rdata_q <= bus_data_i;
    end
  end

  assign busy_o        = (phase != PH_IDLE);
  assign cs_n_o        = busy_o ? ~zone_q : '1;
  assign rd_n_o        = !((phase == PH_ACT) && !we_q);
  assign wr_n_o        = !((phase == PH_ACT) && we_q);
  assign bus_addr_o    = addr_q;
  assign bus_data_o    = wdata_q;
  assign bus_data_oe_o = busy_o && we_q;
  assign rdata_o       = rdata_q;

  a_r1_one_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  a_r6_excl_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_n_o && !wr_n_o));
  a_r6_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |-> ($countones(~cs_n_o) == 1));
  a_r9_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));
endmodule

// File: tb/ext_bus_seq_tb_top.sv
module ext_bus_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, rdy_i = 1'b1;
  logic [15:0] addr_i = '0, wdata_i = '0;
  logic [15:0] cfg_z [3];
  logic [47:0] cfg_i;
  logic [15:0] bus_data_i;
  logic        busy_o, done_o, rd_n_o, wr_n_o, bus_data_oe_o;
  logic [15:0] rdata_o, bus_addr_o, bus_data_o;
  logic [2:0]  cs_n_o;

  int n_checks = 0, n_fail = 0, n_push = 0, n_done = 0;
  bit finished = 0;

  typedef struct {
    bit we; logic [15:0] addr; logic [15:0] data;
    int lead; int act; int trail; int zone; int rdy_after; string tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk_i = ~clk_i;
  assign cfg_i      = {cfg_z[2], cfg_z[1], cfg_z[0]};
  assign bus_data_i = bus_addr_o ^ 16'hA5C3;

  ext_bus_seq dut_i (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .cfg_i, .rdy_i, .bus_data_i,
    .busy_o, .done_o, .rdata_o, .cs_n_o, .rd_n_o, .wr_n_o, .bus_addr_o,
    .bus_data_o, .bus_data_oe_o
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(int rl, int ra, int rt, int wl, int wa, int wt,
                                         bit dbl, bit rdy);
    return {rdy, dbl, 2'(wt), 3'(wa), 2'(wl), 2'(rt), 3'(ra), 2'(rl)};
  endfunction

  // driver: issue one access and push the expected outcome
  task automatic do_acc(bit we, logic [15:0] addr, logic [15:0] wd, int rdy_after, string tag);
    exp_t e;
    int m, l, a, t, base, ws;
    logic [15:0] f;
    while (busy_o) @(negedge clk_i);
    e.zone = (addr[15:14] == 2'd3) ? 2 : int'(addr[15:14]);
    f = cfg_z[e.zone];
    m = f[14] ? 2 : 1;
    if (we) begin l = f[8:7]; a = f[11:9]; t = f[13:12]; end
    else    begin l = f[1:0]; a = f[4:2];  t = f[6:5];   end
    base = a * m + 1;
    ws = (f[15] && rdy_after + 1 > base) ? rdy_after + 1 - base : 0;
    e.we = we; e.addr = addr; e.data = wd; e.lead = l * m; e.act = base + ws;
    e.trail = t * m; e.rdy_after = rdy_after; e.tag = tag;
    exp_q.push_back(e);
    n_push++;
    req_i = 1'b1; we_i = we; addr_i = addr; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk_i);
  endtask

  // monitor / scoreboard
  int lead_n = 0, act_n = 0, trail_n = 0;
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (cs_n_o != 3'b111) begin
        check(busy_o, "R8", "busy during cs", busy_o, 1);
        if (exp_q.size() == 0) check(0, "R9", "access with no request", cs_n_o, 7);
        else begin
          check(cs_n_o == ~(3'b1 << exp_q[0].zone), "R1", "chip select", cs_n_o,
                ~(3'b1 << exp_q[0].zone) & 3'h7);
          check(bus_addr_o == exp_q[0].addr, "R6", "bus address", bus_addr_o, exp_q[0].addr);
          if (exp_q[0].we) begin
            check(bus_data_oe_o && bus_data_o == exp_q[0].data, "R6", "write data",
                  bus_data_o, exp_q[0].data);
            check(rd_n_o, "R6", "read strobe in write", rd_n_o, 1);
          end else check(wr_n_o && !bus_data_oe_o, "R6", "write strobe in read", wr_n_o, 1);
        end
        if (!rd_n_o || !wr_n_o) act_n++;
        else if (act_n == 0) lead_n++;
        else trail_n++;
      end else begin
        check(rd_n_o && wr_n_o, "R6", "strobe without cs", {rd_n_o, wr_n_o}, 3);
      end
      if ((!rd_n_o || !wr_n_o) && exp_q.size() != 0) rdy_i = (act_n > exp_q[0].rdy_after);
      else rdy_i = 1'b1;
      if (done_o) begin
        n_done++;
        check(!busy_o, "R8", "busy at done", busy_o, 0);
        if (exp_q.size() == 0) check(0, "R9", "unexpected done", 1, 0);
        else begin
          check(lead_n == exp_q[0].lead, exp_q[0].tag, "lead cycles", lead_n, exp_q[0].lead);
          check(act_n == exp_q[0].act, exp_q[0].tag, "active cycles", act_n, exp_q[0].act);
          check(trail_n == exp_q[0].trail, exp_q[0].tag, "trail cycles", trail_n, exp_q[0].trail);
          if (!exp_q[0].we)
            check(rdata_o == (exp_q[0].addr ^ 16'hA5C3), "R7", "read data", rdata_o,
                  exp_q[0].addr ^ 16'hA5C3);
          void'(exp_q.pop_front());
        end
        lead_n = 0; act_n = 0; trail_n = 0;
      end
    end
  end

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_push);
    finish_run();
  end

  initial begin
    cfg_z[0] = mk_cfg(1, 0, 0, 1, 0, 0, 0, 0);
    cfg_z[1] = mk_cfg(2, 3, 1, 3, 5, 2, 1, 0);
    cfg_z[2] = mk_cfg(1, 2, 2, 2, 1, 1, 0, 1);
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check(cs_n_o == 3'b111 && rd_n_o && wr_n_o, "R11", "bus idle in reset",
          {cs_n_o, rd_n_o, wr_n_o}, 5'h1f);
    check(!busy_o && !done_o && !bus_data_oe_o, "R11", "status in reset",
          {busy_o, done_o, bus_data_oe_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_acc(0, 16'h0012, 16'h0000, 0, "R3");
    do_acc(1, 16'h0034, 16'hBEEF, 0, "R3");
    do_acc(0, 16'h4100, 16'h0000, 0, "R4");
    do_acc(1, 16'h4200, 16'h1234, 0, "R2");
    do_acc(0, 16'h8001, 16'h0000, 0, "R5");
    do_acc(0, 16'h8002, 16'h0000, 5, "R5");
    do_acc(1, 16'h8003, 16'h5A5A, 3, "R5");
    do_acc(0, 16'hC055, 16'h0000, 1, "R1");
    cfg_z[2] = mk_cfg(1, 2, 2, 2, 1, 1, 0, 0);
    do_acc(0, 16'h8077, 16'h0000, 6, "R5");
    cfg_z[0] = mk_cfg(0, 1, 0, 0, 0, 0, 0, 0);
    do_acc(0, 16'h0101, 16'h0000, 0, "R10");
    do_acc(1, 16'h0102, 16'hC0DE, 0, "R10");
    cfg_z[1] = mk_cfg(3, 7, 3, 1, 0, 0, 1, 0);
    do_acc(0, 16'h7FFF, 16'h0000, 0, "R4");
    // R9: request during a busy access is dropped
    fork
      do_acc(0, 16'h4444, 16'h0000, 0, "R9");
      begin
        repeat (4) @(negedge clk_i);
        req_i = 1'b1; we_i = 1'b1; addr_i = 16'h0999; wdata_i = 16'hDEAD;
        @(negedge clk_i);
        req_i = 1'b0;
      end
    join
    repeat (10) @(negedge clk_i);
    check(n_done == n_push, "R9", "completed access count", n_done, n_push);
    check(cs_n_o == 3'b111 && !busy_o, "R9", "no extra access", cs_n_o, 7);
    finish_run();
  end
endmodule